// File: doc/BRIEF.md
# Quadword Block-Copy DMA Channel

This block is one DMA channel that copies a run of 128-bit quadwords from a source address to a fixed destination window. Software loads a source address, a target offset inside the destination window and a quadword count. It then writes the control register with the start bit set. The channel reads each quadword from the source and writes it to the destination base plus the running target offset, one quadword per beat. When the count runs out, the channel stops by itself and raises its bit in a DMA interrupt status register.

The register port is a plain single-cycle write port with a combinational read path. Registers sit 16 bytes apart. The memory side is a 128-bit master. It holds a request with address, write enable and write data stable until the memory returns ready. Read data is taken in the cycle ready is high. The interrupt output is the OR of the status bits that are also enabled in the mask.

Top module: `qdma_top`

## Requirements
- R1: After reset every mapped register reads 0, `mem_req` is low and `dma_irq` is low.
- R2: The registers are at the following offsets, one every 16 bytes:
  - 0x00: control, with bit 0 the start/busy bit.
  - 0x10: source address.
  - 0x20: target offset.
  - 0x30: quadword count, 16 bits.
  - 0x40: status, with status in [15:0] and mask in [31:16].
  - 0x50: mask, written through bits [15:0].
  Any other offset reads 0.
- R3: A control write with bit 0 set and a nonzero count moves exactly count quadwords. Quadword k is read from source+16k and written unchanged to DST_BASE+target+16k.
- R4: Each quadword is one read beat followed by one write beat. A pending request keeps its address and direction stable until `mem_ready`.
- R5: At completion the count reads 0 and control bit 0 reads 0. Source and target read back advanced by 16 per quadword. Status bit 2 is set.
- R6: A start with count 0 completes at once without any memory request and still sets status bit 2.
- R7: A control write with bit 0 clear during a transfer stops it. No further request is issued, status bit 2 is not set, and the count keeps its remaining value.
- R8: While a transfer is active, writes to the source, target and count registers, and further start writes, are ignored.
- R9: A write to the status offset clears the status bits where the data has 1s and leaves the mask bits unchanged.
- R10: `dma_irq` is high exactly when some status bit and its mask bit are both 1, and falls once that AND is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write beat, 0 for read beat |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 128 | Quadword to write |
| mem_rdata | input | 128 | Quadword returned on a read beat |
| mem_ready | input | 1 | Memory accepts the current beat |
| dma_irq | output | 1 | Interrupt, OR of status AND mask |

## Verification
The bench runs random-length copies with random source data and a memory whose ready is randomly delayed, and compares every destination quadword with its source. A channel that advanced its addresses on an unaccepted beat, or that wrote before reading, would leave misplaced or stale words in the destination. Zero-count starts are watched for any memory traffic and for a missing status bit. Mid-transfer writes to the address and count registers check that a busy channel does not follow them, which would corrupt the copy or leave a nonzero count. Status clears are checked against a preserved mask, and a stop write issued while the memory holds off ready checks that an abort leaves the count untouched and raises no interrupt.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_SRC  = 1;
    localparam int unsigned IDX_TGT  = 2;
    localparam int unsigned IDX_CNT  = 3;
    localparam int unsigned IDX_STAT = 4;
    localparam int unsigned IDX_MASK = 5;

    localparam int unsigned START_BIT = 0;

    typedef struct packed {
        logic ctrl_wr;
        logic src_wr;
        logic tgt_wr;
        logic cnt_wr;
        logic stat_wr;
        logic mask_wr;
    } reg_strobe_t;

endpackage

// File: rtl/qdma_decode.sv
module qdma_decode
    import qdma_pkg::*;
#(
    parameter int unsigned REG_AW = 8,
    parameter int unsigned REG_DW = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NSTAT  = 16
) (
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] ctrl_val,
    input  logic [REG_DW-1:0] src_val,
    input  logic [REG_DW-1:0] tgt_val,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [NSTAT-1:0]  stat_val,
    input  logic [NSTAT-1:0]  mask_val,
    output reg_strobe_t       strobe,
    output logic [REG_DW-1:0] reg_rdata
);
    localparam int unsigned IDX_W = REG_AW - 4;

    logic [IDX_W-1:0] idx;
    assign idx = reg_addr[REG_AW-1:4];

    always_comb begin
        strobe         = '0;
        strobe.ctrl_wr = reg_we && (idx == IDX_W'(IDX_CTRL));
        strobe.src_wr  = reg_we && (idx == IDX_W'(IDX_SRC));
        strobe.tgt_wr  = reg_we && (idx == IDX_W'(IDX_TGT));
        strobe.cnt_wr  = reg_we && (idx == IDX_W'(IDX_CNT));
        strobe.stat_wr = reg_we && (idx == IDX_W'(IDX_STAT));
        strobe.mask_wr = reg_we && (idx == IDX_W'(IDX_MASK));
    end

    always_comb begin
        reg_rdata = '0;
        case (idx)
            IDX_W'(IDX_CTRL): reg_rdata = ctrl_val;
            IDX_W'(IDX_SRC):  reg_rdata = src_val;
            IDX_W'(IDX_TGT):  reg_rdata = tgt_val;
            IDX_W'(IDX_CNT):  reg_rdata = REG_DW'(cnt_val);
            IDX_W'(IDX_STAT): reg_rdata = REG_DW'({mask_val, stat_val});
            IDX_W'(IDX_MASK): reg_rdata = REG_DW'(mask_val);
            default:          reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qdma_seq.sv
module qdma_seq
    import qdma_pkg::*;
#(
    parameter int unsigned REG_DW   = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned QW_W     = 128,
    parameter logic [REG_DW-1:0] DST_BASE = 32'h5000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_strobe_t       strobe,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] ctrl_val,
    output logic [REG_DW-1:0] src_val,
    output logic [REG_DW-1:0] tgt_val,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_DW-1:0] mem_addr,
    output logic [QW_W-1:0]   mem_wdata,
    input  logic [QW_W-1:0]   mem_rdata,
    input  logic              mem_ready
);
    localparam logic [REG_DW-1:0] QW_BYTES = REG_DW'(QW_W / 8);

    typedef struct packed {
        seq_state_e        state;
        logic [REG_DW-1:0] ctrl;
        logic [REG_DW-1:0] src;
        logic [REG_DW-1:0] tgt;
        logic [CNT_W-1:0]  cnt;
        logic [QW_W-1:0]   qbuf;
    } seq_t;

    seq_t seq_q, seq_d;
    logic done_d;
    logic beat_ok;

    assign beat_ok = mem_req && mem_ready;

    always_comb begin
        seq_d  = seq_q;
        done_d = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (strobe.src_wr) seq_d.src = wdata;
                if (strobe.tgt_wr) seq_d.tgt = wdata;
                if (strobe.cnt_wr) seq_d.cnt = wdata[CNT_W-1:0];
                if (strobe.ctrl_wr) begin
                    seq_d.ctrl            = wdata;
                    seq_d.ctrl[START_BIT] = 1'b0;
                    if (wdata[START_BIT]) begin
                        if (seq_q.cnt == '0) done_d = 1'b1;
                        else                 seq_d.state = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (beat_ok) begin
                    seq_d.qbuf  = mem_rdata;
                    seq_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (beat_ok) begin
                    seq_d.src = seq_q.src + QW_BYTES;
                    seq_d.tgt = seq_q.tgt + QW_BYTES;
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                    if (seq_q.cnt == CNT_W'(1)) begin
                        seq_d.state = ST_IDLE;
                        done_d      = 1'b1;
                    end else begin
                        seq_d.state = ST_READ;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase

        // stop request while busy: abort wins over a completing beat
        if ((seq_q.state != ST_IDLE) && strobe.ctrl_wr && !wdata[START_BIT]) begin
            seq_d.state = ST_IDLE;
            seq_d.ctrl  = wdata;
            done_d      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign done      = done_d;
    assign mem_req   = (seq_q.state != ST_IDLE);
    assign mem_we    = (seq_q.state == ST_WRITE);
    assign mem_addr  = (seq_q.state == ST_WRITE) ? (DST_BASE + seq_q.tgt) : seq_q.src;
    assign mem_wdata = seq_q.qbuf;
    assign src_val   = seq_q.src;
    assign tgt_val   = seq_q.tgt;
    assign cnt_val   = seq_q.cnt;

    always_comb begin
        ctrl_val            = seq_q.ctrl;
        ctrl_val[START_BIT] = (seq_q.state != ST_IDLE);
    end
endmodule

// File: rtl/qdma_irq.sv
module qdma_irq #(
    parameter int unsigned REG_DW = 32,
    parameter int unsigned NSTAT  = 16,
    parameter int unsigned CH_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stat_wr,
    input  logic              mask_wr,
    input  logic [REG_DW-1:0] wdata,
    output logic [NSTAT-1:0]  stat_val,
    output logic [NSTAT-1:0]  mask_val,
    output logic              irq
);
    typedef struct packed {
        logic [NSTAT-1:0] stat;
        logic [NSTAT-1:0] mask;
    } irq_t;

    irq_t irq_q, irq_d;
    logic [NSTAT-1:0] set_vec;

    generate
        for (genvar b = 0; b < NSTAT; b++) begin : g_set
            if (b == CH_BIT) begin : g_ch
                assign set_vec[b] = done;
            end else begin : g_other
                assign set_vec[b] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        irq_d = irq_q;
        if (stat_wr) irq_d.stat = irq_q.stat & ~wdata[NSTAT-1:0];
        irq_d.stat = irq_d.stat | set_vec;
        if (mask_wr) irq_d.mask = wdata[NSTAT-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign stat_val = irq_q.stat;
    assign mask_val = irq_q.mask;
    assign irq      = |(irq_q.stat & irq_q.mask);
endmodule

// File: rtl/qdma_top.sv
module qdma_top
    import qdma_pkg::*;
#(
    parameter int unsigned REG_AW = 8,
    parameter int unsigned REG_DW = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned QW_W   = 128,
    parameter int unsigned NSTAT  = 16,
    parameter int unsigned CH_BIT = 2,
    parameter logic [31:0] DST_BASE = 32'h5000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [REG_DW-1:0] mem_addr,
    output logic [QW_W-1:0]   mem_wdata,
    input  logic [QW_W-1:0]   mem_rdata,
    input  logic              mem_ready,
    output logic              dma_irq
);
    reg_strobe_t       strobe;
    logic [REG_DW-1:0] ctrl_val, src_val, tgt_val;
    logic [CNT_W-1:0]  cnt_val;
    logic [NSTAT-1:0]  stat_val, mask_val;
    logic              seq_done;

    qdma_decode #(
        .REG_AW(REG_AW), .REG_DW(REG_DW), .CNT_W(CNT_W), .NSTAT(NSTAT)
    ) u_decode (
        .reg_we(reg_we), .reg_addr(reg_addr),
        .ctrl_val(ctrl_val), .src_val(src_val), .tgt_val(tgt_val),
        .cnt_val(cnt_val), .stat_val(stat_val), .mask_val(mask_val),
        .strobe(strobe), .reg_rdata(reg_rdata)
    );

    qdma_seq #(
        .REG_DW(REG_DW), .CNT_W(CNT_W), .QW_W(QW_W), .DST_BASE(DST_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .wdata(reg_wdata),
        .ctrl_val(ctrl_val), .src_val(src_val), .tgt_val(tgt_val),
        .cnt_val(cnt_val), .done(seq_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    qdma_irq #(
        .REG_DW(REG_DW), .NSTAT(NSTAT), .CH_BIT(CH_BIT)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .done(seq_done),
        .stat_wr(strobe.stat_wr), .mask_wr(strobe.mask_wr), .wdata(reg_wdata),
        .stat_val(stat_val), .mask_val(mask_val), .irq(dma_irq)
    );
endmodule

// File: rtl/qdma_chk.sv
module qdma_chk #(
    parameter int unsigned REG_AW = 8,
    parameter int unsigned REG_DW = 32,
    parameter int unsigned NSTAT  = 16,
    parameter int unsigned CH_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [REG_DW-1:0] mem_addr,
    input logic              done,
    input logic [NSTAT-1:0]  status,
    input logic              dma_irq
);
    logic ctrl_wr, stat_wr;
    assign ctrl_wr = reg_we && (reg_addr[REG_AW-1:4] == '0);
    assign stat_wr = reg_we && (reg_addr[REG_AW-1:4] == (REG_AW-4)'(4));

    // R4: a waiting beat keeps its address and direction
    a_r4_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready && !ctrl_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R4: an accepted read beat is followed by a write beat
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !mem_we && !ctrl_wr |=> mem_req && mem_we);

    // R5: completion lands in the channel status bit
    a_r5_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> status[CH_BIT]);

    // R7: a stop write ends memory traffic
    a_r7_stop_ends_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !reg_wdata[0] |=> !mem_req);

    // R10: clearing every status bit drops the interrupt
    a_r10_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && (reg_wdata[NSTAT-1:0] == '1) && !done |=> !dma_irq);
endmodule

bind qdma_top qdma_chk #(
    .REG_AW(REG_AW), .REG_DW(REG_DW), .NSTAT(NSTAT), .CH_BIT(CH_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .done(seq_done),
    .status(stat_val), .dma_irq(dma_irq)
);

// File: tb/qdma_top_bench.sv
module qdma_top_bench;
    localparam logic [31:0] DST = 32'h5000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;
    logic         dma_irq;

    int checks = 0;
    int fails  = 0;
    int beats  = 0;
    int cyc    = 0;
    bit hold_ready = 1'b0;

    logic [127:0] src_mem [0:63];
    logic [127:0] dst_mem [0:63];

    always #4 clk = ~clk;

    qdma_top u_qdma_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .dma_irq(dma_irq)
    );

    // memory model: decisions at the falling edge hold for the next rising edge
    always @(negedge clk) begin
        mem_ready <= 1'b0;
        if (rst_n && mem_req && !hold_ready && ($urandom % 3 != 0)) begin
            mem_ready <= 1'b1;
            beats = beats + 1;
            if (mem_we) begin
                if (mem_addr[31:28] == DST[31:28]) dst_mem[mem_addr[9:4]] = mem_wdata;
            end else begin
                mem_rdata <= src_mem[mem_addr[9:4]];
            end
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h00, v);
            if (!v[0]) break;
        end
    endtask

    task automatic do_copy(input int n, input bit poke_busy);
        logic [31:0] v, s, t;
        int bad;
        s = 32'($urandom % 8) << 4;
        t = 32'($urandom % 8) << 4;
        for (int i = 0; i < 64; i++) begin
            src_mem[i] = {$urandom, $urandom, $urandom, $urandom};
            dst_mem[i] = '0;
        end
        wr(8'h40, 32'hFFFF);
        wr(8'h10, s); wr(8'h20, t); wr(8'h30, 32'(n));
        wr(8'h00, 32'h1);
        if (poke_busy) begin
            // R8: these must not disturb the running copy
            wr(8'h10, 32'h0000_0300);
            wr(8'h20, 32'h0000_0200);
            wr(8'h30, 32'd77);
            wr(8'h00, 32'h1);
        end
        wait_idle();
        bad = 0;
        for (int k = 0; k < n; k++)
            if (dst_mem[t[9:4] + k] !== src_mem[s[9:4] + k]) bad++;
        check(bad == 0, "R3 copied quadwords", 32'(bad), 32'd0);
        rd(8'h30, v); check(v == 0, "R5 count after done", v, 0);
        rd(8'h00, v); check(v[0] == 1'b0, "R5 start bit after done", v, 0);
        rd(8'h10, v); check(v == s + 32'(16 * n), "R5 source advanced", v, s + 32'(16 * n));
        rd(8'h20, v); check(v == t + 32'(16 * n), "R5 target advanced", v, t + 32'(16 * n));
        rd(8'h40, v); check(v[2] == 1'b1, "R5 status bit 2", v, 32'h4);
    endtask

    initial begin
        logic [31:0] v;
        int b0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin src_mem[i] = '0; dst_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int r = 0; r < 6; r++) begin
            rd(8'(r << 4), v);
            check(v == 0, "R1 register reset value", v, 0);
        end
        check(!mem_req && !dma_irq, "R1 no request and no irq", {30'd0, mem_req, dma_irq}, 0);
        rd(8'h70, v); check(v == 0, "R2 unmapped offset reads 0", v, 0);

        // R2/R10 mask register and irq
        wr(8'h50, 32'h0000_0004);
        rd(8'h40, v); check(v[31:16] == 16'h0004, "R2 mask seen in status high half", v, 32'h0004_0000);

        // R6 zero-count start
        wr(8'h30, 32'd0);
        b0 = beats;
        wr(8'h00, 32'h1);
        repeat (3) @(negedge clk);
        check(beats == b0, "R6 no memory beat on zero count", 32'(beats - b0), 0);
        rd(8'h40, v); check(v[2] == 1'b1, "R6 status bit 2 set", v, 32'h0004_0004);
        check(dma_irq == 1'b1, "R10 irq with masked-in status", {31'd0, dma_irq}, 1);

        // R9 W1C on low half, mask preserved
        wr(8'h40, 32'hFFFF_FFFB);
        rd(8'h40, v); check(v == 32'h0004_0004, "R9 untouched bit kept, mask kept", v, 32'h0004_0004);
        wr(8'h40, 32'h0000_0004);
        rd(8'h40, v); check(v == 32'h0004_0000, "R9 status cleared, mask kept", v, 32'h0004_0000);
        check(dma_irq == 1'b0, "R10 irq falls when AND is zero", {31'd0, dma_irq}, 0);

        // R10 masked-out status gives no irq
        wr(8'h50, 32'h0000_0000);
        wr(8'h00, 32'h1);
        repeat (2) @(negedge clk);
        rd(8'h40, v); check(v == 32'h0000_0004, "R10 status set with mask off", v, 32'h4);
        check(dma_irq == 1'b0, "R10 irq stays low when masked", {31'd0, dma_irq}, 0);
        wr(8'h50, 32'h0000_0004);
        #1 check(dma_irq == 1'b1, "R10 irq rises when mask enables", {31'd0, dma_irq}, 1);

        // R3/R4/R5 copies of various lengths, random ready
        do_copy(1, 1'b0);
        do_copy(8, 1'b0);
        for (int j = 0; j < 6; j++) do_copy(1 + int'($urandom % 8), 1'b0);

        // R8 writes while busy ignored
        do_copy(6, 1'b1);

        // R7 abort with memory holding off
        wr(8'h40, 32'hFFFF);
        hold_ready = 1'b1;
        wr(8'h10, 32'h0); wr(8'h30, 32'd5);
        wr(8'h00, 32'h1);
        repeat (2) @(negedge clk);
        check(mem_req == 1'b1, "R7 transfer running before stop", {31'd0, mem_req}, 1);
        wr(8'h00, 32'h0);
        b0 = beats;
        hold_ready = 1'b0;
        repeat (6) @(negedge clk);
        check(!mem_req && beats == b0, "R7 no request after stop", 32'(beats - b0), 0);
        rd(8'h30, v); check(v == 32'd5, "R7 count keeps remaining value", v, 5);
        rd(8'h40, v); check(v[2] == 1'b0, "R7 no status on stop", v, 32'h0004_0000);
        check(dma_irq == 1'b0, "R7 no irq on stop", {31'd0, dma_irq}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule